// File: doc/BRIEF.md
# Clock Generator Interrupt Flag Unit

This block keeps the interrupt status of a clock generator that runs an internal oscillator and a low-speed crystal oscillator. It records four events in sticky flags: the internal oscillator has finished its stabilization wait, the crystal oscillator has finished its stabilization wait, the crystal has stopped, and the internal oscillator has finished auto-trimming. Each flag has its own enable bit. The block raises one interrupt request line to the interrupt controller while any enabled flag is set.

The oscillators, the stabilization counters and the trimming engine are outside this block. Each one delivers a single-cycle event pulse. The block also watches two level control bits: the crystal enable and the stop-detector enable. When either of them drops from 1 to 0, the block treats it as a crystal stop. Software reaches the block through a plain write port. One selection value loads the enable bits. The other clears flags, one per data bit written as 1. The flag and enable registers are visible on output pins. Every signal here is a control or status pin, so the block has no valid/ready handshake and no back-pressure.

Top module: `cg_irq_unit`

## Requirements
- R1: The flag register has this layout: bit0 is internal-oscillator stabilization done (`evt_irc_stable`), bit1 is crystal stabilization done (`evt_xtal_stable`), bit2 is crystal stopped, and bit3 is auto-trim done (`evt_trim_done`). An event pulse sampled at a rising clock edge sets its flag at that edge.
- R2: `irq_o` is 1 exactly when some bit position has both its flag and its enable set. The enable register uses the same bit positions as the flag register.
- R3: A pulse on `evt_xtal_lost` sets flag bit2.
- R4: A 1-to-0 change of `ctl_xtal_en` between two consecutive clock edges sets flag bit2. A 0-to-1 change has no effect.
- R5: A 1-to-0 change of `ctl_stopdet_en` between two consecutive clock edges sets flag bit2. A 0-to-1 change has no effect.
- R6: A write with `wr_sel`=0 clears every flag whose `wr_data` bit is 1. Data bits that are 0 leave their flags unchanged.
- R7: If a set event and a clear by writing 1 reach the same flag in the same cycle, the set wins and the flag ends at 1.
- R8: A write with `wr_sel`=1 loads `wr_data` into the enable register. Such a write leaves all flags unchanged. Without a set event or a clear, a flag holds its value.
- R9: Reset (`rst_n` low, asynchronous) clears all flags and all enables, forgets the previous control values, and deasserts `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_irc_stable | input | 1 | Pulse: internal oscillator stabilization wait complete |
| evt_xtal_stable | input | 1 | Pulse: crystal stabilization wait complete |
| evt_xtal_lost | input | 1 | Pulse: crystal clock loss detected |
| evt_trim_done | input | 1 | Pulse: internal oscillator auto-trim complete |
| ctl_xtal_en | input | 1 | Crystal enable control bit (level) |
| ctl_stopdet_en | input | 1 | Crystal stop-detector enable control bit (level) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: clear flags by writing 1, 1: load enables |
| wr_data | input | 4 | Write data, one bit per flag position |
| flags_o | output | 4 | Current flag register |
| ien_o | output | 4 | Current enable register |
| irq_o | output | 1 | Interrupt request to the interrupt controller |

## Verification
The bench tests the case where a set and a clear of the same flag arrive together. A design that lets the clear win loses the event, and the flag and `irq_o` read 0 where they should read 1. The bench also raises and drops both control bits separately and together. A design that detects rising edges, or that compares against a stale value, either reports a stop that never happened or misses a real one on bit2. Clear writes with mixed data bits and enable writes that arrive while flags are set check for leakage between the two registers. The bench also checks that `irq_o` follows every enable-and-flag combination, so a flag that is set but masked must not raise the request.

// File: rtl/cg_irq_pkg.sv
package cg_irq_pkg;
  parameter int FLAG_W = 4;

  localparam int IDX_IRC_STABLE  = 0;
  localparam int IDX_XTAL_STABLE = 1;
  localparam int IDX_XTAL_STOP   = 2;
  localparam int IDX_TRIM_DONE   = 3;

  localparam int CTL_W = 2;

  typedef logic [FLAG_W-1:0] flag_vec_t;
endpackage

// File: rtl/cg_fall_det.sv
module cg_fall_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fall_o[i] = prev_q[i] & ~level_i[i];

    // R4 R5: a detected fall means the level read low at this edge
    a_r4_fall_is_low: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[i] |=> !prev_q[i]);
  end
endmodule

// File: rtl/cg_flag_cell.sv
module cg_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/cg_irq_unit.sv
module cg_irq_unit
  import cg_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_irc_stable,
  input  logic              evt_xtal_stable,
  input  logic              evt_xtal_lost,
  input  logic              evt_trim_done,
  input  logic              ctl_xtal_en,
  input  logic              ctl_stopdet_en,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] ien_o,
  output logic              irq_o
);
  logic [CTL_W-1:0] ctl_lvl;
  logic [CTL_W-1:0] ctl_fall;
  flag_vec_t        set_vec;
  flag_vec_t        clr_vec;
  flag_vec_t        flag_q;
  flag_vec_t        ien_q;
  logic             stop_evt;

  assign ctl_lvl = {ctl_stopdet_en, ctl_xtal_en};

  cg_fall_det #(.W(CTL_W)) u_fall (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (ctl_lvl),
    .fall_o  (ctl_fall)
  );

  assign stop_evt = evt_xtal_lost | (|ctl_fall);

  always_comb begin
    set_vec                  = '0;
    set_vec[IDX_IRC_STABLE]  = evt_irc_stable;
    set_vec[IDX_XTAL_STABLE] = evt_xtal_stable;
    set_vec[IDX_XTAL_STOP]   = stop_evt;
    set_vec[IDX_TRIM_DONE]   = evt_trim_done;
  end

  assign clr_vec = (wr_en && !wr_sel) ? wr_data : '0;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    cg_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flag_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ien_q <= '0;
    else if (wr_en && wr_sel) ien_q <= wr_data;
  end

  assign flags_o = flag_q;
  assign ien_o   = ien_q;
  assign irq_o   = |(flag_q & ien_q);

  a_r5_stop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctl_fall) |=> flags_o[IDX_XTAL_STOP]);
  a_r3_lost_sets_stop: assert property (@(posedge clk) disable iff (!rst_n)
    evt_xtal_lost |=> flags_o[IDX_XTAL_STOP]);
  a_r8_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (ien_o == $past(wr_data)));
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_o == '0) |-> !irq_o);
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!irq_o && flags_o == '0 && ien_o == '0));
endmodule

// File: tb/sim_cg_irq_unit.sv
module sim_cg_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       e_irc = 0, e_xs = 0, e_lost = 0, e_trim = 0;
  logic       c_x = 0, c_s = 0;
  logic       w_en = 0, w_sel = 0;
  logic [3:0] w_d = '0;
  logic [3:0] flags_o, ien_o;
  logic       irq_o;

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R9";

  // behavioural reference state
  int m_flags = 0;
  int m_ien   = 0;
  bit m_px = 0, m_ps = 0;

  always #2.5 clk = ~clk;

  cg_irq_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .evt_irc_stable(e_irc), .evt_xtal_stable(e_xs),
    .evt_xtal_lost(e_lost), .evt_trim_done(e_trim),
    .ctl_xtal_en(c_x), .ctl_stopdet_en(c_s),
    .wr_en(w_en), .wr_sel(w_sel), .wr_data(w_d),
    .flags_o(flags_o), .ien_o(ien_o), .irq_o(irq_o)
  );

  task automatic compare();
    bit exp_irq;
    exp_irq = (m_flags & m_ien) != 0;
    vectors++;
    if (flags_o !== m_flags[3:0] || ien_o !== m_ien[3:0] || irq_o !== exp_irq) begin
      errors++;
      $display("FAIL %s: flags=%h ien=%h irq=%b expected flags=%h ien=%h irq=%b",
               cur_req, flags_o, ien_o, irq_o, m_flags[3:0], m_ien[3:0], exp_irq);
    end
  endtask

  // predict the state after the coming rising edge from the inputs now driven
  task automatic predict();
    int setv, clrv;
    bit stop;
    if (!rst_n) begin
      m_flags = 0; m_ien = 0; m_px = 0; m_ps = 0;
      return;
    end
    stop = e_lost || (m_px && !c_x) || (m_ps && !c_s);
    setv = (e_irc ? 1 : 0) + (e_xs ? 2 : 0) + (stop ? 4 : 0) + (e_trim ? 8 : 0);
    clrv = (w_en && !w_sel) ? int'(w_d) : 0;
    m_flags = (m_flags & ~clrv & 15) | setv;
    if (w_en && w_sel) m_ien = int'(w_d);
    m_px = c_x; m_ps = c_s;
  endtask

  // one cycle: check outputs from last edge, drive new inputs, predict
  task automatic step(bit i0, bit i1, bit lost, bit i3, bit cx, bit cs,
                      bit we, bit ws, logic [3:0] wd);
    @(negedge clk);
    compare();
    e_irc = i0; e_xs = i1; e_lost = lost; e_trim = i3;
    c_x = cx; c_s = cs; w_en = we; w_sel = ws; w_d = wd;
    predict();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, c_x, c_s, 0, 0, 4'h0);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R9: reset state with control bits held high during reset
    c_x = 1; c_s = 1;
    predict();
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    idle(2);

    // R1: each event alone, enables zero so no request
    cur_req = "R1";
    step(1, 0, 0, 0, 1, 1, 0, 0, 4'h0);
    step(0, 1, 0, 0, 1, 1, 0, 0, 4'h0);
    step(0, 0, 0, 1, 1, 1, 0, 0, 4'h0);
    idle(1);

    // R8: enable write leaves flags alone
    cur_req = "R8";
    step(0, 0, 0, 0, 1, 1, 1, 1, 4'b0100);
    idle(2);

    // R2: enable a set flag -> request
    cur_req = "R2";
    step(0, 0, 0, 0, 1, 1, 1, 1, 4'b0001);
    idle(1);
    step(0, 0, 0, 0, 1, 1, 1, 1, 4'b1000);
    idle(1);

    // R6: write mixed data clears only the 1 positions
    cur_req = "R6";
    step(0, 0, 0, 0, 1, 1, 1, 0, 4'b0101);
    idle(1);
    step(0, 0, 0, 0, 1, 1, 1, 0, 4'b0000);
    idle(1);
    step(0, 0, 0, 0, 1, 1, 1, 0, 4'b1111);
    idle(1);

    // R4: crystal enable falls, then rises (no effect)
    cur_req = "R4";
    step(0, 0, 0, 0, 0, 1, 0, 0, 4'h0);
    idle(1);
    step(0, 0, 0, 0, 0, 1, 1, 0, 4'b0100);
    step(0, 0, 0, 0, 1, 1, 0, 0, 4'h0);
    idle(2);

    // R5: stop-detector enable falls, then rises (no effect)
    cur_req = "R5";
    step(0, 0, 0, 0, 1, 0, 1, 0, 4'b0100);
    idle(1);
    step(0, 0, 0, 0, 1, 0, 1, 0, 4'b0100);
    step(0, 0, 0, 0, 1, 1, 0, 0, 4'h0);
    idle(1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 4'b0100);
    idle(1);
    step(0, 0, 0, 0, 1, 1, 1, 0, 4'b0100);
    idle(1);

    // R3: lost clock pulse
    cur_req = "R3";
    step(0, 0, 1, 0, 1, 1, 1, 1, 4'b0100);
    idle(2);

    // R7: set and clear on the same flag together
    cur_req = "R7";
    step(0, 0, 1, 0, 1, 1, 1, 0, 4'b0100);
    idle(1);
    step(1, 0, 0, 0, 1, 1, 1, 0, 4'b1111);
    idle(1);
    step(0, 0, 0, 0, 0, 1, 1, 0, 4'b0100);
    idle(1);

    // R2: random traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[0] & r[8], r[1] & r[9], r[2] & r[10] & r[11], r[3] & r[12],
           r[13] | r[14], r[15] | r[16], r[17], r[18], r[22:19]);
    end
    idle(1);

    // R9: asynchronous reset mid-run
    cur_req = "R9";
    step(1, 1, 1, 1, 1, 1, 1, 1, 4'hF);
    idle(1);
    @(negedge clk);
    rst_n = 0;
    #1;
    predict();
    compare();
    @(negedge clk);
    rst_n = 1;
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule